// File: doc/BRIEF.md
# Stop-Mode Power-Down Control Register

This 8-bit control and status register tells a stop-mode entry controller what to do when the processor executes a stop request. It holds a power-down enable and a depth select. The depth select picks either the full power-down state or the partial power-down state. Both control bits may be written only once after reset. After that first write they are frozen until the next reset.

The register also keeps two sticky recovery flags. A one-cycle event pulse sets the matching flag when the chip returns from full or partial power-down. Software reads the flags to learn how it woke up. It clears both flags together by writing a one to an acknowledge position. That write action works on every write, including writes after the control bits are locked.

Top module: `pdctl_reg`

## Requirements
- R1: After reset, rdata (with rd_en high) reads 8'h00, and pd_enable, pd_mode, stop1_sel and stop2_sel are all 0.
- R2: With rd_en high, rdata returns the following fields:
  - bit 4: full-recovery flag
  - bit 3: partial-recovery flag
  - bit 1: enable
  - bit 0: mode
  - bits 7:5 and bit 2: always 0

  With rd_en low, rdata is 8'h00.
- R3: A full_wake pulse sets the full-recovery flag (bit 4) at the next clock edge. The flag stays set until it is acknowledged.
- R4: A part_wake pulse sets the partial-recovery flag (bit 3) at the next clock edge. The flag stays set until it is acknowledged.
- R5: A write with wdata[2]=1 clears both recovery flags at the clock edge. A write with wdata[2]=0 leaves both flags unchanged.
- R6: The first write after reset loads enable from wdata[1] and mode from wdata[0], and locks both bits. Every later write leaves them unchanged until the next reset.
- R7: If a wake pulse and an acknowledge write arrive in the same cycle, the flag for that pulse ends up set.
- R8: The select outputs follow the control bits:
  - pd_enable and pd_mode mirror the enable and mode bits.
  - stop1_sel = enable & ~mode.
  - stop2_sel = enable & mode.
- R9: An acknowledge write after the lock still clears both flags, and it does not change enable or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when rd_en is low |
| full_wake | input | 1 | Pulse on recovery from full power-down |
| part_wake | input | 1 | Pulse on recovery from partial power-down |
| pd_enable | output | 1 | Power-down modes enabled |
| pd_mode | output | 1 | 0 = full, 1 = partial power-down |
| stop1_sel | output | 1 | Stop request goes to full power-down |
| stop2_sel | output | 1 | Stop request goes to partial power-down |

## Verification
The assertions assume that wr_en, wdata and the wake pulses are stable around the clock edge, and that each wake input is a clean level with a meaningful value in every cycle. The stimulus drives every input only on the falling edge, so the inputs are always settled when the rising edge samples them. Random writes, acknowledge bits and wake pulses are mixed freely, including collisions in the same cycle. A second reset partway through the run reopens the write-once window, so the first-write behaviour is exercised more than once.

// File: rtl/pdctl_reg.sv
module pdctl_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          full_wake,
  input  logic          part_wake,
  output logic          pd_enable,
  output logic          pd_mode,
  output logic          stop1_sel,
  output logic          stop2_sel
);
  localparam int FULL_B = 4;
  localparam int PART_B = 3;
  localparam int ACK_B  = 2;
  localparam int EN_B   = 1;
  localparam int MODE_B = 0;

  logic full_q, part_q, en_q, mode_q, locked;
  logic ack;

  assign ack = wr_en & wdata[ACK_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      part_q <= 1'b0;
    end else begin
      full_q <= full_wake | (full_q & ~ack);
      part_q <= part_wake | (part_q & ~ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      en_q   <= wdata[EN_B];
      mode_q <= wdata[MODE_B];
      locked <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[FULL_B] = full_q;
      rdata[PART_B] = part_q;
      rdata[EN_B]   = en_q;
      rdata[MODE_B] = mode_q;
    end
  end

  assign pd_enable = en_q;
  assign pd_mode   = mode_q;
  assign stop1_sel = en_q & ~mode_q;
  assign stop2_sel = en_q & mode_q;
endmodule

module pdctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       full_wake,
  input logic       part_wake,
  input logic       pd_enable,
  input logic       pd_mode,
  input logic       stop1_sel,
  input logic       stop2_sel,
  input logic       full_q,
  input logic       part_q,
  input logic       locked
);
  // R3
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_wake |=> full_q);
  // R4
  part_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_wake |=> part_q);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2] && !full_wake && !part_wake) |=> (!full_q && !part_q));
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(pd_enable) && $stable(pd_mode)));
  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop1_sel, stop2_sel}) && (pd_enable == (stop1_sel | stop2_sel)));
  // R2
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rdata[7:5] == 3'b000 && rdata[2] == 1'b0));
endmodule

bind pdctl_reg pdctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
  .rdata(rdata), .full_wake(full_wake), .part_wake(part_wake),
  .pd_enable(pd_enable), .pd_mode(pd_mode), .stop1_sel(stop1_sel),
  .stop2_sel(stop2_sel), .full_q(full_q), .part_q(part_q), .locked(locked)
);

// File: tb/sim_pdctl_reg.sv
module sim_pdctl_reg;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, full_wake = 0, part_wake = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic pd_enable, pd_mode, stop1_sel, stop2_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_full, m_part, m_en, m_mode, m_lock;

  always #2 clk = ~clk;

  pdctl_reg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .full_wake(full_wake), .part_wake(part_wake),
    .pd_enable(pd_enable), .pd_mode(pd_mode), .stop1_sel(stop1_sel),
    .stop2_sel(stop2_sel));

  function automatic logic [7:0] exp_rd();
    return {3'b000, m_full, m_part, 1'b0, m_en, m_mode};
  endfunction

  function automatic logic [3:0] exp_out();
    return {m_en, m_mode, m_en & ~m_mode, m_en & m_mode};
  endfunction

  task automatic chk(input string tag);
    checks++;
    if (rdata !== exp_rd()) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd());
    end
    checks++;
    if ({pd_enable, pd_mode, stop1_sel, stop2_sel} !== exp_out()) begin
      errors++;
      $display("FAIL %s outputs actual=%b expected=%b", tag,
               {pd_enable, pd_mode, stop1_sel, stop2_sel}, exp_out());
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; full_wake = 0; part_wake = 0; rd_en = 1;
    {m_full, m_part, m_en, m_mode, m_lock} = '0;
    #1;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit f, input bit p,
                     input string tag);
    wr_en = w; wdata = d; full_wake = f; part_wake = p; rd_en = 1;
    @(posedge clk);
    if (w && d[2]) begin m_full = 0; m_part = 0; end
    if (f) m_full = 1;
    if (p) m_part = 1;
    if (w && !m_lock) begin m_en = d[1]; m_mode = d[0]; m_lock = 1; end
    @(negedge clk);
    wr_en = 0; full_wake = 0; part_wake = 0;
    #1 chk(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    do_reset();
    #1 chk("R1");
    rd_en = 0; #1; checks++;
    if (rdata !== 8'h00) begin
      errors++; $display("FAIL R2 rd_en low actual=%h expected=00", rdata);
    end
    rd_en = 1;
    cyc(0, 8'h00, 1, 0, "R3");
    cyc(0, 8'h00, 0, 0, "R3 sticky");
    cyc(0, 8'h00, 0, 1, "R4");
    cyc(1, 8'hFB, 0, 0, "R5 no-ack R6 first R8");
    cyc(1, 8'h00, 0, 0, "R6 ignored");
    cyc(1, 8'h04, 0, 0, "R9 ack after lock");
    cyc(0, 8'h00, 1, 1, "R3 R4 both");
    cyc(1, 8'h04, 1, 0, "R7 collision");
    cyc(1, 8'h04, 0, 0, "R5 clear");
    do_reset();
    #1 chk("R1 second reset");
    cyc(1, 8'h02, 0, 0, "R6 R8 stop1");
    cyc(1, 8'h01, 0, 1, "R6 ignored R4");
    for (int i = 0; i < 400; i++) begin
      if (i == 200) do_reset();
      cyc($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 5) == 0,
          $urandom_range(0, 5) == 0, "R2 R5 R7 random");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule